// File: doc/BRIEF.md
# Byte-Lane Scratch Register with Split-Access Alias

This block is a 32-bit scratch word on a small I/O bus. Software can store a value there and read it back with any access width from one to four bytes, starting at any byte offset inside a 4-byte window. A write changes only the byte lanes it covers. A read returns the covered lanes right-justified and zero-extended. The word is little-endian: byte offset 0 is bits 7:0.

The same word is reachable through two windows. In the direct window, each access completes in a single step. In the split window, every multi-byte access is broken into single-byte transfers that run in ascending address order, one per cycle. While that runs, `busy` is high and new requests are ignored. Both windows must leave the word in the same state and return the same read data. Test software uses the split window to check that a byte-by-byte path agrees with a wide one.

Top module: `scr_lane_reg`

## Requirements
- R1: After reset, the word is 0x00000000 and both `busy` and `done` are low.
- R2: A legal write changes exactly the byte lanes from offset `addr[1:0]` up to offset+size-1, where lane k is bits 8k+7:8k. All other lanes keep their value.
- R3: Bits of `wdata` at or above size×8 have no effect on the word.
- R4: A legal read returns the addressed lanes shifted down so that the lowest addressed lane appears at bits 7:0. All bits above size×8 read as zero.
- R5: An accepted direct-window access (addresses 0xE0–0xE3) raises `done` for one cycle, in the cycle after the request. `busy` stays low throughout.
- R6: An access is illegal when size is 0, size is greater than 4, or offset+size is greater than 4. In either window, an illegal access leaves the word unchanged, raises `done` in the next cycle, and returns `rdata` = 0.
- R7: The split window (addresses 0xE8–0xEB) accesses the same word as the direct window, and it gives the same final word and the same read data for the same access.
- R8: A legal split-window access of N bytes holds `busy` high for exactly N cycles, starting in the cycle after the request. `done` rises in the first cycle in which `busy` is low again.
- R9: A request made while `busy` is high is ignored. It produces no `done` and no change to the word.
- R10: A request to an address outside both windows produces no `done` and leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one-cycle pulse |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | I/O byte address |
| size | input | 3 | Access width in bytes (legal: 1 to 4) |
| wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Split-window transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid while `done` is high |

## Verification
A wrong lane mask or shift shows up as corrupted neighbouring lanes. It appears at the next read of those lanes, so every random write is followed over time by reads through both windows against a reference model. A fault in the sequencer's byte index or step count shows up in the split window in two ways. First, the `busy` length or the position of `done` is off by a cycle, and this is visible on the same access. Second, a byte lands in the wrong lane, and this is visible at the next read. A failed busy gate would let an ignored request corrupt the word, which shows up on the read-back that follows it.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int SCR_BYTES = 4;
    localparam int LANE_W    = $clog2(SCR_BYTES);
    localparam int SIZE_W    = $clog2(SCR_BYTES + 1);
    localparam int DATA_W    = SCR_BYTES * 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [7:0]        byte_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [SIZE_W-1:0] size_t;

    typedef enum logic [1:0] {WIN_NONE, WIN_DIRECT, WIN_SPLIT} win_e;

    typedef struct packed {
        logic  valid;
        logic  wr;
        win_e  win;
        logic  legal;
        lane_t off;
        size_t size;
        word_t wdata;
    } acc_t;

    // Set of byte lanes from off up to off+size-1 (capped at the word)
    function automatic word_t lane_mask(input lane_t off, input size_t size);
        word_t m;
        m = '0;
        for (int b = 0; b < SCR_BYTES; b++) begin
            if (b >= int'(off) && b < int'(off) + int'(size))
                m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

    function automatic logic size_legal(input lane_t off, input size_t size);
        return (size != '0) && (int'(off) + int'(size) <= SCR_BYTES);
    endfunction
endpackage

// File: rtl/scr_win_decode.sv
module scr_win_decode
    import scr_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] DIRECT_BASE = 16'h00E0,
    parameter logic [ADDR_W-1:0] SPLIT_BASE  = 16'h00E8
) (
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  size_t             size,
    input  word_t             wdata,
    output acc_t              acc
);
    logic hit_direct, hit_split;

    assign hit_direct = addr[ADDR_W-1:LANE_W] == DIRECT_BASE[ADDR_W-1:LANE_W];
    assign hit_split  = addr[ADDR_W-1:LANE_W] == SPLIT_BASE[ADDR_W-1:LANE_W];

    always_comb begin
        acc.wr    = wr;
        acc.off   = addr[LANE_W-1:0];
        acc.size  = size;
        acc.wdata = wdata;
        acc.legal = size_legal(addr[LANE_W-1:0], size);
        if (hit_direct)     acc.win = WIN_DIRECT;
        else if (hit_split) acc.win = WIN_SPLIT;
        else                acc.win = WIN_NONE;
        acc.valid = req && (hit_direct || hit_split);
    end
endmodule

// File: rtl/scr_lane_merge.sv
module scr_lane_merge
    import scr_pkg::*;
(
    input  word_t cur,
    input  lane_t off,
    input  size_t size,
    input  word_t wdata,
    output word_t nxt,
    output word_t rd
);
    word_t mask, keep, placed;
    logic [LANE_W+2:0] start;

    always_comb begin
        start  = {off, 3'b000};
        mask   = lane_mask(off, size);
        // discard data above the access width before placing it (R3)
        keep   = wdata & lane_mask('0, size);
        placed = keep << start;
        nxt    = (cur & ~mask) | (placed & mask);
        rd     = (cur & mask) >> start;
    end
endmodule

// File: rtl/scr_byte_seq.sv
module scr_byte_seq
    import scr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  wr,
    input  lane_t off,
    input  size_t size,
    input  word_t wdata,
    input  byte_t step_rbyte,
    output logic  busy,
    output logic  step_en,
    output logic  step_wr,
    output lane_t step_off,
    output byte_t step_wbyte,
    output logic  done,
    output word_t racc
);
    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_e;

    seq_e  state_q;
    lane_t idx_q, last_q, base_q;
    logic  wr_q;
    word_t wdata_q;

    assign busy       = state_q == SEQ_RUN;
    assign step_en    = busy;
    assign step_wr    = wr_q;
    assign step_off   = base_q + idx_q;
    assign step_wbyte = wdata_q[8*idx_q +: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            base_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            racc    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RUN;
                        idx_q   <= '0;
                        last_q  <= lane_t'(size - size_t'(1));
                        base_q  <= off;
                        wr_q    <= wr;
                        wdata_q <= wdata;
                        racc    <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (!wr_q) racc[8*idx_q +: 8] <= step_rbyte;
                    if (idx_q == last_q) begin
                        state_q <= SEQ_IDLE;
                        done    <= 1'b1;
                    end else begin
                        idx_q <= idx_q + lane_t'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scr_lane_reg.sv
module scr_lane_reg
    import scr_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] DIRECT_BASE = 16'h00E0,
    parameter logic [ADDR_W-1:0] SPLIT_BASE  = 16'h00E8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    acc_t  acc;
    word_t scratch_q;
    word_t direct_nxt, direct_rd, step_nxt, step_rd;
    logic  accept, imm_go, seq_start;
    logic  seq_busy, step_en, step_wr, seq_done;
    lane_t step_off;
    byte_t step_wbyte;
    word_t seq_racc;
    logic  imm_done_q;
    word_t imm_rdata_q;

    scr_win_decode #(
        .ADDR_W(ADDR_W), .DIRECT_BASE(DIRECT_BASE), .SPLIT_BASE(SPLIT_BASE)
    ) u_dec (
        .req(req), .wr(wr), .addr(addr), .size(size), .wdata(wdata), .acc(acc)
    );

    // requests are taken only when no split transfer runs (R9, R10)
    assign accept    = acc.valid && !seq_busy;
    assign imm_go    = accept && (acc.win == WIN_DIRECT || !acc.legal);
    assign seq_start = accept && acc.win == WIN_SPLIT && acc.legal;

    scr_lane_merge u_direct (
        .cur(scratch_q), .off(acc.off), .size(acc.size), .wdata(acc.wdata),
        .nxt(direct_nxt), .rd(direct_rd)
    );

    scr_lane_merge u_step (
        .cur(scratch_q), .off(step_off), .size(size_t'(1)), .wdata(word_t'(step_wbyte)),
        .nxt(step_nxt), .rd(step_rd)
    );

    scr_byte_seq u_seq (
        .clk(clk), .rst(rst), .start(seq_start), .wr(acc.wr), .off(acc.off),
        .size(acc.size), .wdata(acc.wdata), .step_rbyte(byte_t'(step_rd)),
        .busy(seq_busy), .step_en(step_en), .step_wr(step_wr), .step_off(step_off),
        .step_wbyte(step_wbyte), .done(seq_done), .racc(seq_racc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q   <= '0;
            imm_done_q  <= 1'b0;
            imm_rdata_q <= '0;
        end else begin
            if (step_en && step_wr)
                scratch_q <= step_nxt;
            else if (imm_go && acc.wr && acc.legal)
                scratch_q <= direct_nxt;
            imm_done_q <= imm_go;
            if (imm_go)
                imm_rdata_q <= (!acc.wr && acc.legal) ? direct_rd : '0;
        end
    end

    assign busy  = seq_busy;
    assign done  = imm_done_q | seq_done;
    assign rdata = seq_done ? seq_racc : imm_rdata_q;
endmodule

// File: rtl/scr_lane_reg_chk.sv
module scr_lane_reg_chk
    import scr_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] DIRECT_BASE = 16'h00E0,
    parameter logic [ADDR_W-1:0] SPLIT_BASE  = 16'h00E8
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [SIZE_W-1:0] size,
    input logic [DATA_W-1:0] wdata,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rdata
);
    logic in_dir, in_spl, ok, take;
    logic [SIZE_W:0] run_q;
    size_t exp_len_q;

    assign in_dir = addr[ADDR_W-1:LANE_W] == DIRECT_BASE[ADDR_W-1:LANE_W];
    assign in_spl = addr[ADDR_W-1:LANE_W] == SPLIT_BASE[ADDR_W-1:LANE_W];
    assign ok     = size_legal(addr[LANE_W-1:0], size);
    assign take   = req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            exp_len_q <= '0;
        end else begin
            if (take && in_spl && ok) exp_len_q <= size;
            run_q <= busy ? run_q + 1'b1 : '0;
        end
    end

    assert_direct_done_R5: assert property (@(posedge clk) disable iff (rst)
        take && in_dir |=> done && !busy);
    assert_bad_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        take && (in_dir || in_spl) && !ok && !wr |=> done && rdata == '0);
    assert_split_busy_R8: assert property (@(posedge clk) disable iff (rst)
        take && in_spl && ok |=> busy && !done);
    assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done && run_q == (SIZE_W+1)'(exp_len_q));
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_no_resp_R10: assert property (@(posedge clk) disable iff (rst)
        take && !in_dir && !in_spl |=> !done);
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> !done);
    // wdata is observed only through the design; no direct property on it
    wire unused_ok = &{1'b0, wdata};
endmodule

bind scr_lane_reg scr_lane_reg_chk #(
    .ADDR_W(ADDR_W), .DIRECT_BASE(DIRECT_BASE), .SPLIT_BASE(SPLIT_BASE)
) u_chk (.*);

// File: tb/scr_lane_reg_tb.sv
`timescale 1ns/1ps
module scr_lane_reg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] addr = '0;
    logic [2:0]  size = '0;
    logic [31:0] wdata = '0;
    logic        busy, done;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;
    logic [31:0] model = '0;

    always #10 clk = ~clk;

    scr_lane_reg u_dut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .size(size),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata)
    );

    function automatic bit legal_f(input int off, input int sz);
        return sz >= 1 && sz <= 4 && off + sz <= 4;
    endfunction

    function automatic logic [31:0] m_write(input logic [31:0] cur, input int off,
                                            input int sz, input logic [31:0] wd);
        logic [31:0] r = cur;
        for (int i = 0; i < sz; i++) r[(off+i)*8 +: 8] = wd[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] cur, input int off, input int sz);
        logic [31:0] r = '0;
        for (int i = 0; i < sz; i++) r[i*8 +: 8] = cur[(off+i)*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input int sz, input bit w,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int lat, output int bcnt);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; size = 3'(sz); wdata = wd;
        @(negedge clk);
        req = 1'b0;
        lat = 1; bcnt = 0;
        while (!done && lat < 12) begin
            if (busy) bcnt++;
            @(negedge clk);
            lat++;
        end
        rd = rdata;
        if (!done) lat = 0;
    endtask

    task automatic xfer(input logic [15:0] a, input int sz, input bit w,
                        input logic [31:0] wd, input string rtag);
        logic [31:0] rd;
        int lat, bcnt, off, exp_lat, exp_b;
        bit split, lg;
        logic [31:0] exp_rd;
        off   = int'(a[1:0]);
        split = a[15:2] == 14'h003A;
        lg    = legal_f(off, sz);
        exp_b   = (split && lg) ? sz : 0;
        exp_lat = (split && lg) ? sz + 1 : 1;
        exp_rd  = (!w && lg) ? m_read(model, off, sz) : 32'h0;
        access(a, sz, w, wd, rd, lat, bcnt);
        if (w && lg) model = m_write(model, off, sz, wd);
        check(lat == exp_lat, split ? "R8 latency" : "R5 latency", lat, exp_lat);
        check(bcnt == exp_b, split ? "R8 busy" : "R5 busy", bcnt, exp_b);
        check(rd == exp_rd, lg ? rtag : "R6", rd, exp_rd);
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat, bcnt;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 outputs", {busy, done}, 0);
        xfer(16'h00E0, 4, 1'b0, 0, "R1");

        // R2 / R4 directed on direct window
        xfer(16'h00E0, 4, 1'b1, 32'h11223344, "R2");
        xfer(16'h00E1, 2, 1'b1, 32'h0000BEEF, "R2");
        xfer(16'h00E0, 4, 1'b0, 0, "R2");
        // R3 high write bits dropped
        xfer(16'h00E2, 1, 1'b1, 32'hFFFFFF5A, "R3");
        xfer(16'h00E0, 4, 1'b0, 0, "R3");
        xfer(16'h00E1, 2, 1'b0, 0, "R4");
        xfer(16'h00E3, 1, 1'b0, 0, "R4");
        // R6 illegal accesses in both windows
        xfer(16'h00E3, 2, 1'b1, 32'hAAAAAAAA, "R6");
        xfer(16'h00EA, 3, 1'b1, 32'hBBBBBBBB, "R6");
        xfer(16'h00E1, 4, 1'b0, 0, "R6");
        xfer(16'h00E8, 0, 1'b0, 0, "R6");
        xfer(16'h00E0, 5, 1'b1, 32'hCCCCCCCC, "R6");
        xfer(16'h00E0, 4, 1'b0, 0, "R6");
        // R7 cross-window agreement
        xfer(16'h00E9, 3, 1'b1, 32'h00A1B2C3, "R7");
        xfer(16'h00E0, 4, 1'b0, 0, "R7");
        xfer(16'h00E2, 2, 1'b1, 32'h00007788, "R7");
        xfer(16'h00E8, 4, 1'b0, 0, "R7");

        // R10 address outside both windows
        access(16'h00E4, 4, 1'b1, 32'h12345678, rd, lat, bcnt);
        check(lat == 0, "R10 no done", lat, 0);
        xfer(16'h00E0, 4, 1'b0, 0, "R10");

        // R9 request while busy is ignored
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 16'h00E8; size = 3'd4; wdata = 32'h0BADF00D;
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 16'h00E0; size = 3'd4; wdata = 32'hDEADBEEF;
        check(busy, "R9 busy", busy, 1);
        @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
        model = 32'h0BADF00D;
        @(negedge clk);
        check(!done, "R9 no extra done", done, 0);
        xfer(16'h00E0, 4, 1'b0, 0, "R9");

        // random mix over both windows
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            a = ($urandom % 2) ? 16'h00E8 : 16'h00E0;
            a[1:0] = 2'($urandom % 4);
            xfer(a, int'($urandom % 6), 1'($urandom % 2), $urandom,
                 a[3] ? "R7" : "R4");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule